// File: doc/BRIEF.md
# Striped Memory Array with Parity Rebuild

This block presents one wide memory to a host and stores it across five independent single-port channel RAMs. Each host word is cut into four equal lanes, and each lane goes to its own data channel. The fifth channel holds the bitwise XOR of the four lanes at the same address. A host write computes that parity word and writes all five channels in the same cycle. A host read returns the four data lanes.

Any one channel can be marked failed while the array stays in service. Host reads then rebuild the missing lane from the three remaining data lanes and parity. Writes still update every other channel, including parity, so the missing data can always be recovered. When the failed channel is the parity channel, reads come straight from the data lanes and no parity is written.

Once the failed channel has been replaced, a rebuild sequencer walks every address in ascending order. At each address it reads the four surviving channels, XORs them and writes the result into the replaced channel. It then clears the degraded state. Host traffic keeps running throughout. Host requests always win the channel ports. Host writes also go to the replaced channel, so addresses the sequencer has already passed stay current.

Top module: `stripe_parity_mem`

## Requirements
- R1: While the array is healthy, a host write drives all five channel write enables together. Data lane i (bits [i*LANE_W +: LANE_W] of the host word) goes to channel i, and channel 4 receives the bitwise XOR of the four lanes at the same address.
- R2: A host read accepted at a rising edge returns its data with `host_rvalid` high for one cycle, after the second rising edge counted from the accepting edge. While healthy, the data equals the word last written to that address.
- R3: A `fail_set` pulse with `fail_id` in 0..4, while not degraded, raises `degraded` and sets `bad_ch` to `fail_id` at the next edge. A `fail_id` of 5 to 7 is ignored.
- R4: While degraded and with no rebuild running, the failed channel's enable stays low. A read still returns the written word, with a failed data lane rebuilt as the XOR of the other four channels.
- R5: While degraded and with no rebuild running, a host write leaves the failed channel untouched and writes the other four channels, parity included, with the values R1 gives.
- R6: With channel 4 (parity) failed, reads return the data lanes directly and host writes store no parity.
- R7: A `rebuild_start` pulse while degraded and idle raises `rebuild_busy`. The sequencer then visits addresses 0 to 2^ADDR_W-1 in ascending order and fills the failed channel with the XOR of the other four. After the last address, `rebuild_busy` and `degraded` both drop, and every channel again satisfies R1.
- R8: A host request in a cycle takes the channel ports, and the sequencer issues no read in that cycle. During a rebuild, host writes also go to the replaced channel. After the rebuild, every address holds the last data the host wrote, whether it was written before or after the sequencer passed it.
- R9: `rebuild_start` has no effect when not degraded. A `fail_set` while already degraded does not change `bad_ch`.
- R10: After reset, `degraded`, `rebuild_busy` and `host_rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Host access request, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | NLANE*LANE_W | Host write word, lane i at [i*LANE_W +: LANE_W] |
| host_rdata | output | NLANE*LANE_W | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid pulse |
| ch_en | output | NLANE+1 | Per-channel RAM enable |
| ch_we | output | NLANE+1 | Per-channel RAM write enable |
| ch_addr | output | (NLANE+1)*ADDR_W | Per-channel address, channel c at [c*ADDR_W +: ADDR_W] |
| ch_wdata | output | (NLANE+1)*LANE_W | Per-channel write data |
| ch_rdata | input | (NLANE+1)*LANE_W | Per-channel read data, one cycle after an enabled read |
| fail_set | input | 1 | Mark channel fail_id as failed |
| fail_id | input | $clog2(NLANE+1) | Channel index to mark failed |
| rebuild_start | input | 1 | Start regenerating the failed channel |
| degraded | output | 1 | One channel is marked failed |
| bad_ch | output | $clog2(NLANE+1) | Index of the failed channel |
| rebuild_busy | output | 1 | Rebuild sequencer running |

## Verification
The bench builds the block with four 8-bit lanes and a 4-bit address. A full rebuild is then only sixteen addresses, so it can be repeated once for each of the five channels, with random host reads and writes mixed in. The bench fills the failed channel's storage with a fixed garbage byte. Any read that touches that channel, and any rebuild address left unwritten, then shows up in the results. The short address space also makes host writes land often on the address the sequencer is working on. This exercises both the path where the sequencer drops its stale result and the path where it retries.

// File: rtl/spm_pkg.sv
package spm_pkg;
  typedef enum logic [1:0] {
    RB_IDLE  = 2'd0,
    RB_READ  = 2'd1,
    RB_WRITE = 2'd2
  } rb_state_e;
endpackage

// File: rtl/spm_write_lanes.sv
module spm_write_lanes #(
  parameter int NLANE  = 4,
  parameter int LANE_W = 16
) (
  input  logic [NLANE*LANE_W-1:0]     host_wdata,
  output logic [(NLANE+1)*LANE_W-1:0] chan_wdata
);
  localparam int NCH = NLANE + 1;

  function automatic logic [LANE_W-1:0] lane_parity(input logic [NLANE*LANE_W-1:0] word);
    logic [LANE_W-1:0] acc;
    acc = '0;
    for (int l = 0; l < NLANE; l++) acc = acc ^ word[l*LANE_W +: LANE_W];
    return acc;
  endfunction

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    assign chan_wdata[i*LANE_W +: LANE_W] = host_wdata[i*LANE_W +: LANE_W];
  end
  assign chan_wdata[(NCH-1)*LANE_W +: LANE_W] = lane_parity(host_wdata);
endmodule

// File: rtl/spm_read_merge.sv
module spm_read_merge #(
  parameter int NLANE    = 4,
  parameter int LANE_W   = 16,
  parameter int CH_IDX_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_issue,
  input  logic                         degraded,
  input  logic [CH_IDX_W-1:0]          bad,
  input  logic [(NLANE+1)*LANE_W-1:0]  ch_rdata,
  output logic [LANE_W-1:0]            reb_value,
  output logic [NLANE*LANE_W-1:0]      host_rdata,
  output logic                         host_rvalid
);
  localparam int NCH = NLANE + 1;

  logic                    pend_q;
  logic                    recon_q;
  logic [CH_IDX_W-1:0]     bad_r;
  logic [NLANE*LANE_W-1:0] merged;

  // XOR of every channel except one: recovers the skipped channel
  function automatic logic [LANE_W-1:0] xor_except(input logic [NCH*LANE_W-1:0] v,
                                                   input logic [CH_IDX_W-1:0] skip);
    logic [LANE_W-1:0] acc;
    acc = '0;
    for (int c = 0; c < NCH; c++)
      if (CH_IDX_W'(c) != skip) acc = acc ^ v[c*LANE_W +: LANE_W];
    return acc;
  endfunction

  for (genvar i = 0; i < NLANE; i++) begin : g_merge
    assign merged[i*LANE_W +: LANE_W] = (recon_q && bad_r == CH_IDX_W'(i))
                                        ? xor_except(ch_rdata, CH_IDX_W'(i))
                                        : ch_rdata[i*LANE_W +: LANE_W];
  end

  assign reb_value = xor_except(ch_rdata, bad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      recon_q     <= 1'b0;
      bad_r       <= '0;
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      pend_q      <= rd_issue;
      recon_q     <= degraded;
      bad_r       <= bad;
      host_rvalid <= pend_q;
      if (pend_q) host_rdata <= merged;
    end
  end

  assert_rvalid_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |=> ##1 host_rvalid);
endmodule

// File: rtl/spm_rebuild_seq.sv
module spm_rebuild_seq
  import spm_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              busy,
  output logic              rd_issue,
  output logic              wr_issue,
  output logic              done,
  output logic [ADDR_W-1:0] reb_addr
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  rb_state_e st_q;
  logic      host_wr;
  logic      retry;
  logic      advance;

  always_comb begin
    host_wr  = host_req && host_we;
    rd_issue = (st_q == RB_READ) && !host_req;
    wr_issue = (st_q == RB_WRITE) && !host_wr;
    // host write elsewhere steals the port: read again; same address: host data is current
    retry    = (st_q == RB_WRITE) && host_wr && (host_addr != reb_addr);
    advance  = (st_q == RB_WRITE) && !retry;
    done     = advance && (reb_addr == LAST_ADDR);
    busy     = (st_q != RB_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= RB_IDLE;
      reb_addr <= '0;
    end else begin
      unique case (st_q)
        RB_IDLE:  if (start) begin
                    st_q     <= RB_READ;
                    reb_addr <= '0;
                  end
        RB_READ:  if (rd_issue) st_q <= RB_WRITE;
        RB_WRITE: begin
                    if (retry)      st_q <= RB_READ;
                    else if (done)  st_q <= RB_IDLE;
                    else begin
                      st_q     <= RB_READ;
                      reb_addr <= reb_addr + 1'b1;
                    end
                  end
        default:  st_q <= RB_IDLE;
      endcase
    end
  end

  assert_yield_to_host_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |-> !host_req);
  assert_addr_ascends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && reb_addr != $past(reb_addr)) |-> reb_addr == $past(reb_addr) + 1'b1);
endmodule

// File: rtl/stripe_parity_mem.sv
module stripe_parity_mem #(
  parameter int NLANE  = 4,
  parameter int LANE_W = 16,
  parameter int ADDR_W = 10,
  localparam int NCH      = NLANE + 1,
  localparam int CH_IDX_W = $clog2(NCH),
  localparam int WORD_W   = NLANE * LANE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_req,
  input  logic                    host_we,
  input  logic [ADDR_W-1:0]       host_addr,
  input  logic [WORD_W-1:0]       host_wdata,
  output logic [WORD_W-1:0]       host_rdata,
  output logic                    host_rvalid,
  output logic [NCH-1:0]          ch_en,
  output logic [NCH-1:0]          ch_we,
  output logic [NCH*ADDR_W-1:0]   ch_addr,
  output logic [NCH*LANE_W-1:0]   ch_wdata,
  input  logic [NCH*LANE_W-1:0]   ch_rdata,
  input  logic                    fail_set,
  input  logic [CH_IDX_W-1:0]     fail_id,
  input  logic                    rebuild_start,
  output logic                    degraded,
  output logic [CH_IDX_W-1:0]     bad_ch,
  output logic                    rebuild_busy
);
  localparam logic [CH_IDX_W-1:0] LAST_CH = CH_IDX_W'(NCH - 1);

  logic                  degraded_q;
  logic [CH_IDX_W-1:0]   bad_q;
  logic                  start_ok;
  logic                  rb_busy, rb_rd, rb_wr, rb_done;
  logic [ADDR_W-1:0]     reb_addr;
  logic [LANE_W-1:0]     reb_value;
  logic [NCH*LANE_W-1:0] host_chan_wdata;
  logic                  host_rd;

  assign host_rd  = host_req && !host_we;
  assign start_ok = rebuild_start && degraded_q && !rb_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      degraded_q <= 1'b0;
      bad_q      <= '0;
    end else if (rb_done) begin
      degraded_q <= 1'b0;
    end else if (fail_set && !degraded_q && fail_id <= LAST_CH) begin
      degraded_q <= 1'b1;
      bad_q      <= fail_id;
    end
  end

  spm_write_lanes #(.NLANE(NLANE), .LANE_W(LANE_W)) u_write_lanes (
    .host_wdata (host_wdata),
    .chan_wdata (host_chan_wdata)
  );

  spm_read_merge #(.NLANE(NLANE), .LANE_W(LANE_W), .CH_IDX_W(CH_IDX_W)) u_read_merge (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_issue    (host_rd),
    .degraded    (degraded_q),
    .bad         (bad_q),
    .ch_rdata    (ch_rdata),
    .reb_value   (reb_value),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid)
  );

  spm_rebuild_seq #(.ADDR_W(ADDR_W)) u_rebuild_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_ok),
    .host_req  (host_req),
    .host_we   (host_we),
    .host_addr (host_addr),
    .busy      (rb_busy),
    .rd_issue  (rb_rd),
    .wr_issue  (rb_wr),
    .done      (rb_done),
    .reb_addr  (reb_addr)
  );

  // per-channel port steering: host first, then the rebuild sequencer
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic              is_bad;
    logic              c_en, c_we;
    logic [ADDR_W-1:0] c_addr;
    logic [LANE_W-1:0] c_wdata;

    assign is_bad = degraded_q && (bad_q == CH_IDX_W'(c));

    always_comb begin
      c_en    = 1'b0;
      c_we    = 1'b0;
      c_addr  = host_addr;
      c_wdata = host_chan_wdata[c*LANE_W +: LANE_W];
      if (host_req && host_we) begin
        c_en = !is_bad || rb_busy;
        c_we = c_en;
      end else if (is_bad) begin
        if (rb_wr) begin
          c_en    = 1'b1;
          c_we    = 1'b1;
          c_addr  = reb_addr;
          c_wdata = reb_value;
        end
      end else if (host_req) begin
        c_en = 1'b1;
      end else if (rb_rd) begin
        c_en   = 1'b1;
        c_addr = reb_addr;
      end
    end

    assign ch_en[c]                      = c_en;
    assign ch_we[c]                      = c_we;
    assign ch_addr[c*ADDR_W +: ADDR_W]   = c_addr;
    assign ch_wdata[c*LANE_W +: LANE_W]  = c_wdata;
  end

  assign degraded     = degraded_q;
  assign bad_ch       = bad_q;
  assign rebuild_busy = rb_busy;

  assert_full_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_we && !degraded_q) |-> (ch_we == {NCH{1'b1}}));
  assert_skip_failed_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_we && degraded_q && !rb_busy) |-> ($countones(ch_we) == NCH - 1 && !ch_we[bad_q]));
  assert_failed_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (degraded_q && !rb_busy) |-> !ch_en[bad_q]);
  assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rb_busy) |-> !degraded_q);
endmodule

// File: tb/stripe_parity_mem_bench.sv
module stripe_parity_mem_bench;
  localparam int NLANE = 4, LANE_W = 8, ADDR_W = 4;
  localparam int NCH = NLANE + 1, DEPTH = 1 << ADDR_W, W = NLANE * LANE_W, CIW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_req = 0, host_we = 0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [W-1:0] host_wdata = '0, host_rdata;
  logic host_rvalid;
  logic [NCH-1:0] ch_en, ch_we;
  logic [NCH*ADDR_W-1:0] ch_addr;
  logic [NCH*LANE_W-1:0] ch_wdata, ch_rdata;
  logic fail_set = 0, rebuild_start = 0;
  logic [CIW-1:0] fail_id = '0, bad_ch;
  logic degraded, rebuild_busy;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  stripe_parity_mem #(.NLANE(NLANE), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_stripe_parity_mem (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .ch_en(ch_en), .ch_we(ch_we), .ch_addr(ch_addr), .ch_wdata(ch_wdata), .ch_rdata(ch_rdata),
    .fail_set(fail_set), .fail_id(fail_id), .rebuild_start(rebuild_start),
    .degraded(degraded), .bad_ch(bad_ch), .rebuild_busy(rebuild_busy));

  // five channel RAMs, one-cycle read latency
  logic [LANE_W-1:0] mem [NCH][DEPTH];
  logic [LANE_W-1:0] rd_q [NCH];
  always @(posedge clk)
    for (int c = 0; c < NCH; c++)
      if (ch_en[c]) begin
        if (ch_we[c]) mem[c][ch_addr[c*ADDR_W +: ADDR_W]] <= ch_wdata[c*LANE_W +: LANE_W];
        else          rd_q[c] <= mem[c][ch_addr[c*ADDR_W +: ADDR_W]];
      end
  always_comb
    for (int c = 0; c < NCH; c++) ch_rdata[c*LANE_W +: LANE_W] = rd_q[c];

  logic [W-1:0] ref_mem [DEPTH];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected content of channel c: data lane, or odd-count-of-ones per bit for parity
  function automatic logic [LANE_W-1:0] exp_chan(int c, int a);
    logic [LANE_W-1:0] p;
    if (c < NLANE) return ref_mem[a][c*LANE_W +: LANE_W];
    for (int b = 0; b < LANE_W; b++) begin
      int n = 0;
      for (int l = 0; l < NLANE; l++) n += int'(ref_mem[a][l*LANE_W + b]);
      p[b] = (n % 2) == 1;
    end
    return p;
  endfunction

  task automatic sweep(input string tag);
    int bad = 0;
    for (int a = 0; a < DEPTH; a++)
      for (int c = 0; c < NCH; c++)
        if (mem[c][a] !== exp_chan(c, a)) bad++;
    check(bad == 0, tag, 64'(bad), 64'd0);
  endtask

  task automatic do_write(input int a, input logic [W-1:0] d);
    @(negedge clk);
    host_req = 1; host_we = 1; host_addr = ADDR_W'(a); host_wdata = d;
    @(negedge clk);
    host_req = 0; host_we = 0;
    ref_mem[a] = d;
  endtask

  task automatic do_read(input int a, input string tag, input bit chk_idle, input int k);
    @(negedge clk);
    host_req = 1; host_we = 0; host_addr = ADDR_W'(a);
    #1;
    if (chk_idle) check(ch_en[k] == 1'b0, "R4 failed channel enable low on read", 64'(ch_en), 64'd0);
    @(negedge clk);
    host_req = 0;
    check(host_rvalid == 1'b0, "R2 rvalid not early", 64'(host_rvalid), 64'd0);
    @(negedge clk);
    check(host_rvalid == 1'b1, "R2 rvalid on second edge", 64'(host_rvalid), 64'd1);
    check(host_rdata == ref_mem[a], tag, 64'(host_rdata), 64'(ref_mem[a]));
  endtask

  task automatic pulse_fail(input int id);
    @(negedge clk); fail_set = 1; fail_id = CIW'(id);
    @(negedge clk); fail_set = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); rebuild_start = 1;
    @(negedge clk); rebuild_start = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0417));
    for (int c = 0; c < NCH; c++) begin
      rd_q[c] = '0;
      for (int a = 0; a < DEPTH; a++) mem[c][a] = '0;
    end
    for (int a = 0; a < DEPTH; a++) ref_mem[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!degraded && !rebuild_busy && !host_rvalid, "R10 reset state",
          64'({degraded, rebuild_busy, host_rvalid}), 64'd0);

    // fill all addresses, check striping and parity
    for (int a = 0; a < DEPTH; a++) do_write(a, W'($urandom));
    do_write(3, 32'h0000_0000);
    do_write(4, 32'hFFFF_FFFF);
    do_write(5, 32'h8001_00FF);
    sweep("R1 lanes and parity after healthy writes");
    for (int a = 0; a < 6; a++) do_read(a, "R2 healthy read data", 0, 0);

    pulse_start();
    check(!rebuild_busy, "R9 start ignored when healthy", 64'(rebuild_busy), 64'd0);
    pulse_fail(6);
    check(!degraded, "R3 out-of-range fail id ignored", 64'(degraded), 64'd0);

    for (int k = 0; k < NCH; k++) begin
      int cyc;
      pulse_fail(k);
      check(degraded && bad_ch == CIW'(k), "R3 channel marked failed", 64'({degraded, bad_ch}), 64'({1'b1, CIW'(k)}));
      pulse_fail((k + 1) % NCH);
      check(bad_ch == CIW'(k), "R9 second fail ignored", 64'(bad_ch), 64'(k));
      for (int a = 0; a < DEPTH; a++) mem[k][a] = 8'hA5;
      for (int i = 0; i < 4; i++)
        do_read((i * 5 + k) % DEPTH, k == NLANE ? "R6 direct read with parity failed" : "R4 rebuilt read", 1, k);
      for (int i = 0; i < 3; i++) begin
        int a = (i * 7 + k) % DEPTH;
        do_write(a, W'($urandom));
        check(mem[k][a] == 8'hA5, k == NLANE ? "R6 parity write suppressed" : "R5 failed channel untouched",
              64'(mem[k][a]), 64'hA5);
        for (int c = 0; c < NCH; c++)
          if (c != k) check(mem[c][a] == exp_chan(c, a), "R5 surviving channels written", 64'(mem[c][a]), 64'(exp_chan(c, a)));
        do_read(a, "R4 read after degraded write", 1, k);
      end

      pulse_start();
      check(rebuild_busy, "R7 rebuild starts", 64'(rebuild_busy), 64'd1);
      cyc = 0;
      while (rebuild_busy && cyc < 3000) begin
        int r = int'($urandom % 4);
        if (r == 0) do_write(int'($urandom % DEPTH), W'($urandom));
        else if (r == 1) do_read(int'($urandom % DEPTH), "R8 read during rebuild", 0, k);
        else @(negedge clk);
        cyc++;
      end
      check(!rebuild_busy && !degraded, "R7 rebuild finishes and clears degraded",
            64'({rebuild_busy, degraded}), 64'd0);
      sweep("R8 all channels current after rebuild with host traffic");
      do_read(k, "R7 healthy read after rebuild", 0, 0);
    end

    // mixed healthy traffic
    for (int i = 0; i < 120; i++) begin
      if ($urandom % 2) do_write(int'($urandom % DEPTH), W'($urandom));
      else do_read(int'($urandom % DEPTH), "R2 random healthy read", 0, 0);
    end
    sweep("R1 final consistency");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule